// File: doc/BRIEF.md
# LED Driver Control Register Slave (Two-Wire Write Path)

This block is the serial control port of a three-bank LED driver. It watches a two-wire serial bus (clock line plus an open-drain data line), oversamples both lines with the system clock, and recognises start, stop and repeated-start conditions. When a transaction names this device with the write direction, the block takes a register-address byte and then one data byte. It stores the data into one of four sparse control registers. Every byte it accepts is acknowledged by pulling the data line low for the ninth clock.

The four registers drive parallel outputs. The first is a general enable register with five enable bits. Two registers carry a five-bit brightness code for the two display banks. The last carries a two-bit brightness code for the indicator. Unused bits are forced to fixed values and can never be written. An active-low reset pin restores all registers to their power-on values immediately. Writes need no flow control: the register outputs are plain levels, there is no valid/ready pair, and the bus master is the only source of timing.

Top module: `i2c_ledctl_regs`

## Requirements
- R1: While `rst_n` is low, the outputs are `gp_o`=0x20, `bank_a_o`=0xE0, `bank_b_o`=0xE0 and `ind_o`=0xFC.
- R2: Driving `rst_n` low at any time after registers were written returns all four outputs to the R1 values at once.
- R3: A start (data falling while clock is high) or a repeated start always restarts address reception. A stop (data rising while clock is high) returns the bus logic to idle, and a byte cut short by a stop writes nothing.
- R4: The first byte is the 7-bit device address (MSB first) followed by a direction bit. It is acknowledged only when the address equals `dev_addr` and the direction bit is 0. Any other first byte is not acknowledged, and nothing is written until the next start.
- R5: The slave acknowledges by pulling data low during the 9th clock of the address byte, the register-address byte and the single data byte. A fourth or later byte in the same transaction is not acknowledged and is not stored.
- R6: A write to register 0x10 stores data bits 4:0 (the five enable bits). `gp_o` then reads {2'b00, 1'b1, bits 4:0}.
- R7: A write to 0xA0 or 0xB0 stores a 5-bit brightness code from data bits 4:0. The matching output reads {3'b111, code}, and the other bank is unchanged.
- R8: A write to 0xC0 stores a 2-bit code from data bits 1:0. `ind_o` then reads {6'b111111, code}.
- R9: A write to any other register address is acknowledged on all three bytes, and no output changes.
- R10: `sda_oe` changes only while the synchronised clock line is low, except when a start or stop aborts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Active-low hardware reset; restores all register defaults |
| dev_addr | input | 7 | Device address this slave answers to (for example 0x36 or 0x38) |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the open-drain data line low (acknowledge) |
| gp_o | output | 8 | General enable register (address 0x10) |
| bank_a_o | output | 8 | First display bank brightness register (address 0xA0) |
| bank_b_o | output | 8 | Second display bank brightness register (address 0xB0) |
| ind_o | output | 8 | Indicator brightness register (address 0xC0) |

## Verification
The assertions assume that the bus master changes data only while the clock is low, and that the clock stays in each level for several system cycles. This lets every synchronised edge be seen and a stop never lands in the middle of an acknowledge. The bench drives each bus half period for ten system cycles. It moves data seven cycles into the low phase, after the slave has released its acknowledge. It issues starts and stops only with the clock high and the slave released, so the stimulus stays inside those assumptions.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;
  localparam int BYTE_W  = 8;
  localparam int DEV_W   = 7;
  localparam int N_REGS  = 4;
  localparam int CNT_W   = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] RA_GP     = 8'h10;
  localparam logic [BYTE_W-1:0] RA_BANK_A = 8'hA0;
  localparam logic [BYTE_W-1:0] RA_BANK_B = 8'hB0;
  localparam logic [BYTE_W-1:0] RA_IND    = 8'hC0;

  // writable bits per register; the rest are fixed at the init value
  localparam logic [BYTE_W-1:0] KEEP_GP   = 8'h1F;
  localparam logic [BYTE_W-1:0] KEEP_BANK = 8'h1F;
  localparam logic [BYTE_W-1:0] KEEP_IND  = 8'h03;

  localparam logic [BYTE_W-1:0] INIT_GP   = 8'h20;
  localparam logic [BYTE_W-1:0] INIT_BANK = 8'hE0;
  localparam logic [BYTE_W-1:0] INIT_IND  = 8'hFC;

  typedef enum logic [1:0] {BUS_IDLE, BUS_RX, BUS_ACK, BUS_SKIP} bus_state_t;
  typedef enum logic [1:0] {PH_DEV, PH_REG, PH_DATA, PH_EXTRA} phase_t;

  function automatic logic [BYTE_W-1:0] reg_addr(input int idx);
    case (idx)
      0:       return RA_GP;
      1:       return RA_BANK_A;
      2:       return RA_BANK_B;
      default: return RA_IND;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] reg_keep(input int idx);
    case (idx)
      0:       return KEEP_GP;
      1, 2:    return KEEP_BANK;
      default: return KEEP_IND;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] reg_init(input int idx);
    case (idx)
      0:       return INIT_GP;
      1, 2:    return INIT_BANK;
      default: return INIT_IND;
    endcase
  endfunction
endpackage

// File: rtl/ledctl_sync.sv
module ledctl_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_d
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar w = 0; w < WIDTH; w++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < STAGES; k++) chain[k][w] <= 1'b1;
          dout_d[w] <= 1'b1;
        end else begin
          chain[0][w] <= din[w];
          for (int k = 1; k < STAGES; k++) chain[k][w] <= chain[k-1][w];
          dout_d[w] <= chain[STAGES-1][w];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ledctl_bus_fsm.sv
module ledctl_bus_fsm
  import ledctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_d,
  input  logic              sda_d,
  input  logic [DEV_W-1:0]  dev_addr,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  bus_state_t        state_q;
  phase_t            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] shreg_q;
  logic              byte_rdy_q;
  logic              ack_go_q;
  logic [BYTE_W-1:0] reg_sel_q;

  logic start_c, stop_c, scl_rise, scl_fall, accept_c;
  logic [BYTE_W-1:0] next_byte;

  assign start_c   = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c    = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign next_byte = {shreg_q, sda_s};

  always_comb begin
    case (phase_q)
      PH_DEV:  accept_c = (next_byte[BYTE_W-1:1] == dev_addr) && !next_byte[0];
      PH_REG:  accept_c = 1'b1;
      PH_DATA: accept_c = 1'b1;
      default: accept_c = 1'b0;
    endcase
  end

  function automatic phase_t step_phase(input phase_t p);
    case (p)
      PH_DEV:  return PH_REG;
      PH_REG:  return PH_DATA;
      default: return PH_EXTRA;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= BUS_IDLE;
      phase_q    <= PH_DEV;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_rdy_q <= 1'b0;
      ack_go_q   <= 1'b0;
      reg_sel_q  <= '0;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        state_q    <= BUS_RX;
        phase_q    <= PH_DEV;
        bit_cnt_q  <= '0;
        byte_rdy_q <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_c) begin
        state_q    <= BUS_IDLE;
        byte_rdy_q <= 1'b0;
        sda_oe     <= 1'b0;
      end else begin
        case (state_q)
          BUS_RX: begin
            if (scl_rise && !byte_rdy_q) begin
              shreg_q   <= next_byte[BYTE_W-2:0];
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == CNT_W'(BYTE_W-1)) begin
                byte_rdy_q <= 1'b1;
                ack_go_q   <= accept_c;
                if (phase_q == PH_REG) reg_sel_q <= next_byte;
                if (phase_q == PH_DATA) begin
                  wr_en   <= 1'b1;
                  wr_addr <= reg_sel_q;
                  wr_data <= next_byte;
                end
              end
            end else if (scl_fall && byte_rdy_q) begin
              byte_rdy_q <= 1'b0;
              if (ack_go_q) begin
                sda_oe  <= 1'b1;
                state_q <= BUS_ACK;
              end else begin
                state_q <= BUS_SKIP;
              end
            end
          end
          BUS_ACK: begin
            if (scl_fall) begin
              sda_oe    <= 1'b0;
              state_q   <= BUS_RX;
              bit_cnt_q <= '0;
              phase_q   <= step_phase(phase_q);
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_ack_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  p_ack_fall_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_s || $past(start_c || stop_c)));
  p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c && !start_c |=> state_q == BUS_IDLE && !sda_oe);
  p_start_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> state_q == BUS_RX && phase_q == PH_DEV && bit_cnt_q == '0);
  p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_write_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> phase_q == PH_DATA && byte_rdy_q);
endmodule

// File: rtl/ledctl_regfile.sv
module ledctl_regfile
  import ledctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] gp_o,
  output logic [BYTE_W-1:0] bank_a_o,
  output logic [BYTE_W-1:0] bank_b_o,
  output logic [BYTE_W-1:0] ind_o
);
  logic [N_REGS-1:0][BYTE_W-1:0] regs_q;
  logic [N_REGS-1:0]             hit;

  generate
    for (genvar i = 0; i < N_REGS; i++) begin : g_hit
      assign hit[i] = wr_en && (wr_addr == reg_addr(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) regs_q[i] <= reg_init(i);
    end else begin
      for (int i = 0; i < N_REGS; i++)
        if (hit[i])
          regs_q[i] <= (wr_data & reg_keep(i)) | (reg_init(i) & ~reg_keep(i));
    end
  end

  assign gp_o     = regs_q[0];
  assign bank_a_o = regs_q[1];
  assign bank_b_o = regs_q[2];
  assign ind_o    = regs_q[3];

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hit == '0 |=> $stable(regs_q));
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/i2c_ledctl_regs.sv
module i2c_ledctl_regs
  import ledctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [BYTE_W-1:0] gp_o,
  output logic [BYTE_W-1:0] bank_a_o,
  output logic [BYTE_W-1:0] bank_b_o,
  output logic [BYTE_W-1:0] ind_o
);
  logic [1:0] line_s, line_d;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  ledctl_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    ({scl_i, sda_i}),
    .dout   (line_s),
    .dout_d (line_d)
  );

  ledctl_bus_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (line_s[1]),
    .sda_s    (line_s[0]),
    .scl_d    (line_d[1]),
    .sda_d    (line_d[0]),
    .dev_addr (dev_addr),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  ledctl_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .gp_o     (gp_o),
    .bank_a_o (bank_a_o),
    .bank_b_o (bank_b_o),
    .ind_o    (ind_o)
  );
endmodule

// File: tb/sim_i2c_ledctl_regs.sv
module sim_i2c_ledctl_regs;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [6:0] dev_addr = 7'h36;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] gp_o, bank_a_o, bank_b_o, ind_o;
  logic       sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] m_gp = 8'h20, m_a = 8'hE0, m_b = 8'hE0, m_c = 8'hFC;

  i2c_ledctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .gp_o(gp_o), .bank_a_o(bank_a_o), .bank_b_o(bank_b_o), .ind_o(ind_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check(req, {gp_o, bank_a_o, bank_b_o, ind_o}, {m_gp, m_a, m_b, m_c});
  endtask

  task automatic bus_start();
    wait_n(7); sda_m = 1'b1; wait_n(3); scl = 1'b1; wait_n(10);
    sda_m = 1'b0; wait_n(10); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(7); sda_m = 1'b0; wait_n(3); scl = 1'b1; wait_n(10);
    sda_m = 1'b1; wait_n(10);
  endtask

  task automatic bit_out(input logic b);
    wait_n(7); sda_m = b; wait_n(3); scl = 1'b1; wait_n(10); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    wait_n(7); sda_m = 1'b1; wait_n(3); scl = 1'b1; wait_n(5);
    ack = ~sda_bus;
    wait_n(5); scl = 1'b0;
  endtask

  task automatic write_txn(input logic [6:0] dev, input logic [7:0] ra,
                           input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(ra, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
    wait_n(6);
  endtask

  logic [2:0] acks;
  logic       a0, a1, a2, a3;

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait_n(5);
    // R1: defaults while reset held
    check("R1", {gp_o, bank_a_o, bank_b_o, ind_o}, 32'h20E0E0FC);
    check("R1 no ack", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    wait_n(20);

    // R6: every enable pattern, upper bits varied to prove they are forced
    for (int c = 0; c < 32; c++) begin
      logic [7:0] d;
      d = {3'(c * 5), 5'(c)};
      write_txn(7'h36, 8'h10, d, acks);
      m_gp = 8'h20 | (d & 8'h1F);
      check("R6 ack", {29'd0, acks}, 32'd7);
      check_all("R6");
    end

    // R7: both display banks, all codes
    for (int c = 0; c < 32; c++) begin
      logic [7:0] d;
      d = {3'(c + 3), 5'(c)};
      write_txn(7'h36, 8'hA0, d, acks);
      m_a = 8'hE0 | (d & 8'h1F);
      check_all("R7 bank A");
      d = {3'(c), 5'(31 - c)};
      write_txn(7'h36, 8'hB0, d, acks);
      m_b = 8'hE0 | (d & 8'h1F);
      check_all("R7 bank B");
    end

    // R8: indicator codes
    for (int c = 0; c < 4; c++) begin
      logic [7:0] d;
      d = {6'(c * 11 + 5), 2'(c)};
      write_txn(7'h36, 8'hC0, d, acks);
      m_c = 8'hFC | (d & 8'h03);
      check_all("R8");
    end

    // R9: unmapped register addresses acknowledged, no change
    for (int ra = 0; ra < 256; ra += 5) begin
      if (ra == 'h10 || ra == 'hA0 || ra == 'hB0 || ra == 'hC0) continue;
      write_txn(7'h36, 8'(ra), 8'(ra ^ 'h5A), acks);
      check("R9 ack", {29'd0, acks}, 32'd7);
      check_all("R9");
    end

    // R4: wrong device address and read direction
    write_txn(7'h38, 8'hA0, 8'h03, acks);
    check("R4 wrong addr ack", {29'd0, acks}, 32'd0);
    check_all("R4 wrong addr");
    bus_start();
    send_byte({7'h36, 1'b1}, a0);
    send_byte(8'hB0, a1);
    bus_stop();
    wait_n(6);
    check("R4 read nack", {30'd0, a0, a1}, 32'd0);
    check_all("R4 read");

    // R4: other configured address
    dev_addr = 7'h38;
    write_txn(7'h38, 8'hC0, 8'h01, acks);
    m_c = 8'hFD;
    check("R4 alt addr ack", {29'd0, acks}, 32'd7);
    check_all("R4 alt addr");
    write_txn(7'h36, 8'hC0, 8'h02, acks);
    check("R4 old addr nack", {29'd0, acks}, 32'd0);
    check_all("R4 old addr");
    dev_addr = 7'h36;

    // R5: extra byte not acknowledged nor stored
    bus_start();
    send_byte({7'h36, 1'b0}, a0);
    send_byte(8'hA0, a1);
    send_byte(8'h15, a2);
    send_byte(8'h0A, a3);
    bus_stop();
    wait_n(6);
    m_a = 8'hF5;
    check("R5 acks", {28'd0, a0, a1, a2, a3}, 32'hE);
    check_all("R5 extra byte");

    // R3: repeated start in place of the data byte
    bus_start();
    send_byte({7'h36, 1'b0}, a0);
    send_byte(8'hA0, a1);
    bus_start();
    send_byte({7'h36, 1'b0}, a2);
    send_byte(8'hB0, a3);
    send_byte(8'h0C, a0);
    bus_stop();
    wait_n(6);
    m_b = 8'hEC;
    check("R3 restart acks", {30'd0, a2, a3}, 32'd3);
    check_all("R3 repeated start");

    // R3: stop in the middle of the data byte writes nothing
    bus_start();
    send_byte({7'h36, 1'b0}, a0);
    send_byte(8'h10, a1);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    wait_n(6);
    check_all("R3 aborted byte");
    write_txn(7'h36, 8'h10, 8'h1B, acks);
    m_gp = 8'h3B;
    check("R3 after abort ack", {29'd0, acks}, 32'd7);
    check_all("R3 after abort");

    // R2: reset pin restores defaults
    rst_n = 1'b0;
    wait_n(2);
    m_gp = 8'h20; m_a = 8'hE0; m_b = 8'hE0; m_c = 8'hFC;
    check_all("R2 reset");
    wait_n(4);
    rst_n = 1'b1;
    wait_n(10);
    check_all("R2 after release");
    write_txn(7'h36, 8'hB0, 8'h11, acks);
    m_b = 8'hF1;
    check_all("R2 usable after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule